// File: doc/BRIEF.md
# Delay setting update controller

This block sits between two sources of delay codes and a chain of four delay elements. One source is a periodic phase-shift generator and the other is a core-driven input. Each source delivers a 7-bit delay code in Gray form. A select input picks the source. The chosen code is decoded to binary and placed in a staging register, together with a signed phase offset and three control settings. The staging register loads only during a one-cycle update strobe. That strobe comes from a free-running 3-bit counter and recurs once every eight clocks.

Every element output is computed from the staged values, so all elements switch on the same clock edge. The element at the pin may carry the code plus the offset, clamped to the 7-bit range. The other active elements carry the plain code. Inactive elements carry zero. A bypass setting sets every element to zero delay. A modeled total delay adds the intrinsic delay of each active element to the sum of the active settings.

Top module: `dly_update_ctrl`

## Requirements
- R1: The selected 7-bit input code is taken as Gray code and decoded to binary. Each active element other than element 0 presents that binary value.
- R2: `src_sel` = 0 selects `gen_code`. `src_sel` = 1 selects `core_code`.
- R3: When `use_off` = 1, element 0 presents the binary code plus `phase_off`, where `phase_off` is read as 7-bit two's complement. The result is clamped to 0..127. When `use_off` = 0, element 0 presents the plain binary code.
- R4: `elem_cnt` = k activates elements 0..k, so 1 to 4 elements are active. Bit i of `elem_mask` marks element i as active. Element i occupies bits `[7*i+6 : 7*i]` of `elem_set`. Inactive elements present 0.
- R5: `upd_en` is high for exactly one cycle in every eight, when the counter reads 7. The counter reads 0 in the first cycle after reset is released, so the first strobe comes in cycle 7.
- R6: Inputs are sampled only at the clock edge that ends an `upd_en` cycle. No input change made at any other time reaches the outputs.
- R7: A staged `bypass` = 1 gives `bypass_act` = 1, `elem_mask` = 0, all element settings 0 and `total_dly` = 0.
- R8: `total_dly` equals (number of active elements) × INTRINSIC (default 5), plus the sum of the active element settings.
- R9: The synchronous reset clears the counter and all staged values to zero. After reset: `upd_en` = 0, `elem_mask` = 0001, all settings 0, `bypass_act` = 0 and `total_dly` = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the staging register |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | Code source: 0 generator, 1 core |
| gen_code | input | 7 | Gray-coded code from the phase-shift generator |
| core_code | input | 7 | Gray-coded code from core logic |
| phase_off | input | 7 | Signed phase offset applied to element 0 |
| use_off | input | 1 | Applies the offset to element 0 |
| elem_cnt | input | 2 | Number of active elements minus one |
| bypass | input | 1 | Requests zero delay on all elements |
| upd_en | output | 1 | One-cycle update strobe |
| elem_set | output | 28 | Per-element binary settings, element 0 in the low bits |
| elem_mask | output | 4 | Active-element mask |
| bypass_act | output | 1 | Staged bypass in effect |
| total_dly | output | 10 | Modeled total chain delay |

## Verification
The assertions assume that reset is held for at least two clocks before any output is checked. They also assume that the update strobe owes its timing to nothing but the counter. The value-stability properties therefore treat every edge without a strobe as an edge where nothing is loaded. The stimulus meets these conditions with a multi-cycle reset at the start. It then changes the inputs freely in the middle of each update window, including just before and just after the strobe. The bench model checks that only the values present on the strobe edge ever appear at the outputs.

// File: rtl/dly_update_ctrl.sv
module dly_update_ctrl #(
  parameter int W         = 7,
  parameter int N_ELEM    = 4,
  parameter int CNT_W     = 3,
  parameter int UPD_PHASE = 7,
  parameter int INTRINSIC = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  src_sel,
  input  logic [W-1:0]          gen_code,
  input  logic [W-1:0]          core_code,
  input  logic [W-1:0]          phase_off,
  input  logic                  use_off,
  input  logic [1:0]            elem_cnt,
  input  logic                  bypass,
  output logic                  upd_en,
  output logic [N_ELEM*W-1:0]   elem_set,
  output logic [N_ELEM-1:0]     elem_mask,
  output logic                  bypass_act,
  output logic [9:0]            total_dly
);
  localparam int        SEL_W = 2;
  localparam logic [W:0] CODE_MAX = (W+1)'((1 << W) - 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sel_gray, sel_bin;
  logic [W-1:0]     stg_code, stg_off;
  logic             stg_use, stg_byp;
  logic [SEL_W-1:0] stg_cnt;
  logic [W+1:0]     sum_raw;
  logic [W-1:0]     pin_set;

  assign upd_en   = (cnt == CNT_W'(UPD_PHASE));
  assign sel_gray = src_sel ? core_code : gen_code;

  always_comb begin
    sel_bin[W-1] = sel_gray[W-1];
    for (int i = W-2; i >= 0; i--)
      sel_bin[i] = sel_bin[i+1] ^ sel_gray[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      stg_code <= '0;
      stg_off  <= '0;
      stg_use  <= 1'b0;
      stg_byp  <= 1'b0;
      stg_cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (upd_en) begin
        stg_code <= sel_bin;
        stg_off  <= phase_off;
        stg_use  <= use_off;
        stg_byp  <= bypass;
        stg_cnt  <= elem_cnt;
      end
    end
  end

  assign sum_raw = {2'b00, stg_code} + {{2{stg_off[W-1]}}, stg_off};

  always_comb begin
    if (sum_raw[W+1])
      pin_set = '0;
    else if (sum_raw[W:0] > CODE_MAX)
      pin_set = CODE_MAX[W-1:0];
    else
      pin_set = sum_raw[W-1:0];
  end

  assign bypass_act = stg_byp;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
    logic act;
    assign act          = !stg_byp && (stg_cnt >= SEL_W'(i));
    assign elem_mask[i] = act;
    if (i == 0) begin : g_pin
      assign elem_set[i*W +: W] = !act ? '0 : (stg_use ? pin_set : stg_code);
    end else begin : g_far
      assign elem_set[i*W +: W] = act ? stg_code : '0;
    end
  end

  always_comb begin
    total_dly = '0;
    for (int i = 0; i < N_ELEM; i++)
      if (elem_mask[i])
        total_dly = total_dly + 10'(INTRINSIC) + 10'(elem_set[i*W +: W]);
  end
endmodule

module dly_update_ctrl_chk #(
  parameter int W      = 7,
  parameter int N_ELEM = 4,
  parameter int CNT_W  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                upd_en,
  input logic [N_ELEM*W-1:0] elem_set,
  input logic [N_ELEM-1:0]   elem_mask,
  input logic                bypass_act,
  input logic [9:0]          total_dly
);
  localparam int PERIOD = 1 << CNT_W;
  logic             live, seen;
  logic [CNT_W:0]   gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= 1'b0;
      seen <= 1'b0;
      gap  <= '0;
    end else begin
      live <= 1'b1;
      if (upd_en) begin
        seen <= 1'b1;
        gap  <= '0;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> !upd_en);

  a_r5_period: assert property (@(posedge clk) disable iff (rst)
    (upd_en && seen) |-> (gap == (CNT_W+1)'(PERIOD-1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(upd_en)) |-> ($stable(elem_set) && $stable(elem_mask) && $stable(bypass_act)));

  a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
    bypass_act |-> (elem_mask == '0 && elem_set == '0 && total_dly == '0));

  a_r4_contiguous: assert property (@(posedge clk) disable iff (rst)
    !bypass_act |-> (elem_mask[0] && (((elem_mask + 1'b1) & elem_mask) == '0)));

  for (genvar i = 0; i < N_ELEM; i++) begin : g_idle
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !elem_mask[i] |-> (elem_set[i*W +: W] == '0));
  end
endmodule

bind dly_update_ctrl dly_update_ctrl_chk #(.W(W), .N_ELEM(N_ELEM), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .upd_en(upd_en), .elem_set(elem_set),
  .elem_mask(elem_mask), .bypass_act(bypass_act), .total_dly(total_dly));

// File: tb/dly_update_ctrl_test.sv
module dly_update_ctrl_test;
  logic clk = 0, rst = 1;
  logic src_sel = 0, use_off = 0, bypass = 0;
  logic [6:0] gen_code = 0, core_code = 0, phase_off = 0;
  logic [1:0] elem_cnt = 0;
  logic upd_en, bypass_act;
  logic [27:0] elem_set;
  logic [3:0] elem_mask;
  logic [9:0] total_dly;

  int checks = 0, errors = 0, cyc = 0;
  int m_cnt = 0, m_code = 0, m_off = 0, m_use = 0, m_byp = 0, m_n = 0;

  always #2 clk = ~clk;

  dly_update_ctrl uut (.clk, .rst, .src_sel, .gen_code, .core_code, .phase_off,
    .use_off, .elem_cnt, .bypass, .upd_en, .elem_set, .elem_mask, .bypass_act, .total_dly);

  function automatic int to_bin(int g);
    int b = 0;
    for (int s = 0; s < 7; s++) b = b ^ (g >> s);
    return b & 127;
  endfunction

  function automatic int signed7(int v);
    return (v >= 64) ? v - 128 : v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_code = 0; m_off = 0; m_use = 0; m_byp = 0; m_n = 0;
    end else begin
      if (m_cnt == 7) begin
        m_code = to_bin(src_sel ? core_code : gen_code);
        m_off = signed7(phase_off); m_use = use_off; m_byp = bypass; m_n = elem_cnt;
      end
      m_cnt = (m_cnt + 1) % 8;
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R5 watchdog expired: actual cycle %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int e, tot;
      tot = 0;
      chk("R5 upd_en", upd_en, (m_cnt == 7) ? 1 : 0);
      chk("R7 bypass_act", bypass_act, m_byp);
      chk("R4 R7 elem_mask", elem_mask, m_byp ? 0 : ((1 << (m_n + 1)) - 1));
      for (int i = 0; i < 4; i++) begin
        if (m_byp || i > m_n) e = 0;
        else if (i == 0 && m_use != 0) begin
          e = m_code + m_off;
          if (e < 0) e = 0;
          if (e > 127) e = 127;
        end else e = m_code;
        if (!(m_byp || i > m_n)) tot += 5 + e;
        chk(i == 0 ? "R3 R2 R6 elem0" : "R1 R2 R4 R6 elem", elem_set[i*7 +: 7], e);
      end
      chk("R8 total_dly", total_dly, tot);
    end
  end

  task automatic drive(int s, int g, int c, int o, int u, int n, int b);
    src_sel = s[0]; gen_code = g[6:0]; core_code = c[6:0];
    phase_off = o[6:0]; use_off = u[0]; elem_cnt = n[1:0]; bypass = b[0];
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    step(3);
    rst = 0;
    #0.5;
    chk("R9 reset upd_en", upd_en, 0);
    chk("R9 reset mask", elem_mask, 1);
    chk("R9 reset settings", elem_set, 0);
    chk("R9 reset total", total_dly, 5);
    chk("R9 reset bypass", bypass_act, 0);
    // Directed corners: each setting is held over one full window
    drive(0, 7'b1000000, 0, 63, 1, 3, 0); step(8);  // R3 clamp high (gray 1000000 = 127)
    drive(1, 0, 7'b0000001, 64, 1, 0, 0); step(8);  // R3 clamp low, R2 core source
    drive(0, 7'b0000110, 0, 2, 1, 1, 0); step(8);   // gray 0000110 -> 4
    drive(1, 5, 7'b0101010, 0, 0, 2, 0); step(8);   // R1 decode
    drive(0, 33, 44, 5, 1, 3, 1); step(8);          // R7 bypass
    // R6: changes between strobes must stay invisible
    for (int k = 0; k < 16; k++) begin
      drive(k % 2, k * 9, k * 13, k * 7, k % 3 == 0, k % 4, k == 5);
      step(1);
    end
    for (int k = 0; k < 2000; k++) begin
      drive($urandom % 2, $urandom % 128, $urandom % 128, $urandom % 128,
            $urandom % 2, $urandom % 4, ($urandom % 6) == 0);
      step(1 + $urandom % 5);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule